// File: doc/BRIEF.md
# Debug Serial Command Receiver

This block is the write side of a half-duplex, SPI-style debug port for a small processor core. While the select line is low, each rising edge of the serial clock moves one data bit into a 32-bit shift register, most significant bit first. The host may send any number of clocks. Only the latest 32 bits count, so a host can flush the register with zeros and then send its word.

The rising edge of select is the commit event. At that edge the upper half of the word (the control field) and the lower half (the instruction field) go to holding registers. Control bits in that same word decide which registers load. Start, step and stop requests cross into the core clock domain through toggle flags and two-flop synchronizers. Each request becomes one pulse, one core cycle wide. The control register, the instruction word and its bypass-valid flag stay steady for the core to read while select is high.

Top module: `dbg_cmd_rx`

## Requirements
- R1: While `rst` is high, `ctl_q` and `ins_q` read zero, `ins_vld` is low and no run-control pulse is asserted.
- R2: Bits enter MSB-first. After 32 serial clocks, the first bit sent is word bit 31. Word bits [31:16] form the control field and bits [15:0] form the instruction field.
- R3: When more than 32 serial clocks are given while select is low, only the last 32 bits sent form the committed word.
- R4: Serial clocks that arrive while select is high leave the shift register unchanged. A later commit with no new clocks reproduces the previous word.
- R5: On a select rising edge, `ctl_q` loads the whole control field only if control bit 4 (word bit 20, load) is 1. Otherwise `ctl_q` keeps its value.
- R6: On a select rising edge, `ins_vld` takes the value of control bit 3 (word bit 19, bypass). When that bit is 1, `ins_q` loads the instruction field. When it is 0, `ins_q` keeps its value.
- R7: Control bits 0, 1 and 2 (word bits 16, 17 and 18) request start, step and stop. Each bit that is set in a committed word gives exactly one pulse, one `clk` cycle wide, on `start_p`, `step_p` or `stop_p` within four `clk` cycles of the select rising edge. A bit that is clear gives no pulse.
- R8: Back-to-back commits that carry the same request bit each produce their own pulse.
- R9: While select stays low, `ctl_q`, `ins_q` and `ins_vld` do not change, however many bits are shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Core-domain reset, active high |
| dbg_sclk | input | 1 | Serial clock from the debug host |
| dbg_sel | input | 1 | Select; low = receive, rising edge = commit |
| dbg_sdi | input | 1 | Serial data in, MSB first |
| ctl_q | output | 16 | Committed control register |
| ins_q | output | 16 | Instruction holding register |
| ins_vld | output | 1 | Instruction bypass valid flag |
| start_p | output | 1 | Start request pulse, core domain |
| step_p | output | 1 | Step request pulse, core domain |
| stop_p | output | 1 | Stop request pulse, core domain |

## Verification
A shift register that holds the wrong bits shows up only at the next commit, as wrong `ctl_q` or `ins_q` values, or as an unexpected run pulse. Because of this, every scenario commits a word and then compares both holding registers. A stuck or skipped toggle flag shows up in the core domain within four `clk` cycles of the select edge, as a missing or doubled pulse. Each commit therefore counts the pulses over a short window and then again over a longer one. Bits shifted while select is low must stay invisible until the commit, so the holding registers are sampled throughout each shift.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

    localparam int WORD_W = 32;
    localparam int CTL_W  = 16;
    localparam int INS_W  = 16;
    localparam int N_REQ  = 3;

    // control-field bit positions (behavioural: host encodes against these)
    localparam int CB_START  = 0;
    localparam int CB_STEP   = 1;
    localparam int CB_STOP   = 2;
    localparam int CB_BYPASS = 3;
    localparam int CB_LOAD   = 4;

    typedef enum int {
        REQ_START = 0,
        REQ_STEP  = 1,
        REQ_STOP  = 2
    } run_req_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [INS_W-1:0] ins;
    } cmd_word_t;

    function automatic logic [N_REQ-1:0] run_bits(input logic [CTL_W-1:0] c);
        logic [N_REQ-1:0] r;
        r[REQ_START] = c[CB_START];
        r[REQ_STEP]  = c[CB_STEP];
        r[REQ_STOP]  = c[CB_STOP];
        return r;
    endfunction

endpackage

// File: rtl/dbg_rx_shift.sv
module dbg_rx_shift
    import dbg_rx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         sclk,
    input  logic         sel,
    input  logic         sdi,
    output logic [W-1:0] word
);

    logic [W-1:0] sr;

    // no reset: the host always shifts a full word before committing
    always_ff @(posedge sclk) begin
        if (!sel) begin
            sr <= {sr[W-2:0], sdi};
        end
    end

    assign word = sr;

endmodule

// File: rtl/dbg_rx_commit.sv
module dbg_rx_commit
    import dbg_rx_pkg::*;
(
    input  logic               sel,
    input  logic               rst,
    input  cmd_word_t          word,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [INS_W-1:0]   ins_q,
    output logic               ins_vld,
    output logic [N_REQ-1:0]   req_tgl
);

    logic [N_REQ-1:0] req_now;

    assign req_now = run_bits(word.ctl);

    // select rising edge is the commit clock; core reset clears asynchronously
    always_ff @(posedge sel or posedge rst) begin
        if (rst) begin
            ctl_q   <= '0;
            ins_q   <= '0;
            ins_vld <= 1'b0;
            req_tgl <= '0;
        end else begin
            if (word.ctl[CB_LOAD]) begin
                ctl_q <= word.ctl;
            end
            if (word.ctl[CB_BYPASS]) begin
                ins_q <= word.ins;
            end
            ins_vld <= word.ctl[CB_BYPASS];
            req_tgl <= req_tgl ^ req_now;
        end
    end

endmodule

// File: rtl/dbg_rx_sync.sv
module dbg_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl,
    output logic pulse
);

    localparam int LAST = STAGES - 1;

    // [0..LAST] synchronizer, [STAGES] edge-detect history
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], tgl};
        end
    end

    assign pulse = chain[STAGES] ^ chain[LAST];

endmodule

// File: rtl/dbg_cmd_rx.sv
module dbg_cmd_rx
    import dbg_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbg_sclk,
    input  logic             dbg_sel,
    input  logic             dbg_sdi,
    output logic [CTL_W-1:0] ctl_q,
    output logic [INS_W-1:0] ins_q,
    output logic             ins_vld,
    output logic             start_p,
    output logic             step_p,
    output logic             stop_p
);

    logic [WORD_W-1:0] raw_word;
    cmd_word_t         word;
    logic [N_REQ-1:0]  req_tgl;
    logic [N_REQ-1:0]  req_pulse;

    dbg_rx_shift #(.W(WORD_W)) u_shift (
        .sclk (dbg_sclk),
        .sel  (dbg_sel),
        .sdi  (dbg_sdi),
        .word (raw_word)
    );

    assign word = cmd_word_t'(raw_word);

    dbg_rx_commit u_commit (
        .sel     (dbg_sel),
        .rst     (rst),
        .word    (word),
        .ctl_q   (ctl_q),
        .ins_q   (ins_q),
        .ins_vld (ins_vld),
        .req_tgl (req_tgl)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_sync
        dbg_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .tgl   (req_tgl[g]),
            .pulse (req_pulse[g])
        );
    end

    assign start_p = req_pulse[REQ_START];
    assign step_p  = req_pulse[REQ_STEP];
    assign stop_p  = req_pulse[REQ_STOP];

endmodule

// File: rtl/dbg_cmd_rx_chk.sv
module dbg_cmd_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        dbg_sel,
    input logic [15:0] ctl_q,
    input logic [15:0] ins_q,
    input logic        ins_vld,
    input logic        start_p,
    input logic        step_p,
    input logic        stop_p
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ctl_q == 16'h0 && ins_q == 16'h0 && !ins_vld
                 && !start_p && !step_p && !stop_p));

    p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
        start_p |=> !start_p);

    p_step_single_r7: assert property (@(posedge clk) disable iff (rst)
        step_p |=> !step_p);

    p_stop_single_r7: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !stop_p);

    p_hold_while_low_r9: assert property (@(posedge clk) disable iff (rst)
        (!dbg_sel && $past(!dbg_sel)) |->
            ($stable(ctl_q) && $stable(ins_q) && $stable(ins_vld)));

endmodule

bind dbg_cmd_rx dbg_cmd_rx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dbg_sel (dbg_sel),
    .ctl_q   (ctl_q),
    .ins_q   (ins_q),
    .ins_vld (ins_vld),
    .start_p (start_p),
    .step_p  (step_p),
    .stop_p  (stop_p)
);

// File: tb/dbg_cmd_rx_test.sv
module dbg_cmd_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_sclk = 1'b0;
    logic        dbg_sel = 1'b1;
    logic        dbg_sdi = 1'b0;
    logic [15:0] ctl_q;
    logic [15:0] ins_q;
    logic        ins_vld;
    logic        start_p;
    logic        step_p;
    logic        stop_p;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_step = 0;
    int n_stop = 0;

    dbg_cmd_rx uut (
        .clk      (clk),
        .rst      (rst),
        .dbg_sclk (dbg_sclk),
        .dbg_sel  (dbg_sel),
        .dbg_sdi  (dbg_sdi),
        .ctl_q    (ctl_q),
        .ins_q    (ins_q),
        .ins_vld  (ins_vld),
        .start_p  (start_p),
        .step_p   (step_p),
        .stop_p   (stop_p)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        n_start <= n_start + int'(start_p);
        n_step  <= n_step + int'(step_p);
        n_stop  <= n_stop + int'(stop_p);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clock_bits(input logic [63:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            dbg_sdi = bits[i];
            #10 dbg_sclk = 1'b1;
            #10 dbg_sclk = 1'b0;
        end
    endtask

    // shift a word (optionally preceded by junk bits) and commit it
    task automatic send(input logic [31:0] w, input logic [31:0] pre, input int npre);
        logic [15:0] c0;
        logic [15:0] i0;
        c0 = ctl_q;
        i0 = ins_q;
        dbg_sel = 1'b0;
        #15;
        clock_bits({32'h0, pre}, npre);
        clock_bits({32'h0, w}, 16);
        check("R9 ctl mid-shift", {16'h0, ctl_q}, {16'h0, c0});
        clock_bits({32'h0, w}, 32);
        #10;
        check("R9 ins before commit", {16'h0, ins_q}, {16'h0, i0});
        dbg_sel = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (6) @(negedge clk);
        check("R1 ctl", {16'h0, ctl_q}, 32'h0);
        check("R1 ins", {16'h0, ins_q}, 32'h0);
        check("R1 vld", {31'h0, ins_vld}, 32'h0);
        check("R1 pulses", n_start + n_step + n_stop, 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ctl_load();
        send({16'hA510, 16'h1234}, 32'h0, 0);
        check("R2 R5 ctl loaded", {16'h0, ctl_q}, 32'hA510);
        check("R6 ins kept", {16'h0, ins_q}, 32'h0);
        check("R6 vld low", {31'h0, ins_vld}, 32'h0);
        check("R7 no pulses", n_start + n_step + n_stop, 32'h0);
    endtask

    task automatic t_no_load();
        send({16'h3300, 16'h5555}, 32'h0, 0);
        check("R5 ctl kept", {16'h0, ctl_q}, 32'hA510);
    endtask

    task automatic t_bypass();
        send({16'h0008, 16'hBEEF}, 32'h0, 0);
        check("R6 ins loaded", {16'h0, ins_q}, 32'hBEEF);
        check("R6 vld set", {31'h0, ins_vld}, 32'h1);
        check("R5 ctl kept", {16'h0, ctl_q}, 32'hA510);
        send({16'h0000, 16'h1111}, 32'h0, 0);
        check("R6 vld cleared", {31'h0, ins_vld}, 32'h0);
        check("R6 ins kept", {16'h0, ins_q}, 32'hBEEF);
    endtask

    task automatic t_flush();
        send({16'h0018, 16'h0F0F}, 32'hFF, 8);
        check("R3 ctl last32", {16'h0, ctl_q}, 32'h0018);
        check("R3 ins last32", {16'h0, ins_q}, 32'h0F0F);
    endtask

    task automatic t_sel_high_clocks();
        dbg_sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #10 dbg_sclk = 1'b1;
            #10 dbg_sclk = 1'b0;
        end
        #10 dbg_sel = 1'b0;
        #20 dbg_sel = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 ctl same", {16'h0, ctl_q}, 32'h0018);
        check("R4 ins same", {16'h0, ins_q}, 32'h0F0F);
        check("R4 vld same", {31'h0, ins_vld}, 32'h1);
    endtask

    task automatic commit_run(input logic [15:0] ctl, input int es, input int ep, input int eo,
                              input string tag);
        int s0;
        int p0;
        int o0;
        s0 = n_start;
        p0 = n_step;
        o0 = n_stop;
        dbg_sel = 1'b0;
        #15;
        clock_bits({32'h0, ctl, 16'h0}, 32);
        #10 dbg_sel = 1'b1;
        repeat (4) @(negedge clk);
        check({tag, " start early"}, n_start - s0, es);
        check({tag, " step early"}, n_step - p0, ep);
        check({tag, " stop early"}, n_stop - o0, eo);
        repeat (10) @(negedge clk);
        check({tag, " start total"}, n_start - s0, es);
        check({tag, " step total"}, n_step - p0, ep);
        check({tag, " stop total"}, n_stop - o0, eo);
    endtask

    task automatic t_run();
        commit_run(16'h0001, 1, 0, 0, "R7 start");
        commit_run(16'h0006, 0, 1, 1, "R7 step+stop");
    endtask

    task automatic t_repeat();
        commit_run(16'h0004, 0, 0, 1, "R8 stop first");
        commit_run(16'h0004, 0, 0, 1, "R8 stop again");
        commit_run(16'h0007, 1, 1, 1, "R8 all");
    endtask

    initial begin
        t_reset();
        t_ctl_load();
        t_no_load();
        t_bypass();
        t_flush();
        t_sel_high_clocks();
        t_run();
        t_repeat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule